// File: doc/BRIEF.md
# Fall-Through FIFO with Ready-Flag Handshakes

This block is a first-in first-out store of 64 four-bit words. It is written through a shift-in strobe and read through an active-low shift-out strobe. Two registered flags report the state of its two ends. `in_rdy` shows that the input stage is free. `out_rdy` shows that a valid word sits on the outputs. A word taken in falls through an interior circular buffer to the output stage without any further action, and the latency is a fixed number of cycles. The data outputs are three-state and are released whenever `oe_n` is high. An active-low master reset clears the block at once, without waiting for a clock, and the release of that reset is synchronised to `clk`.

All strobes are sampled on `clk`, and each pulse moves exactly one word. Two instances can be chained without any glue logic. The first instance's `dout` drives the second's `din`. The first's `out_rdy` drives the second's `shift_in`, and the second's `in_rdy` drives the first's `shift_out_n`. The flag and strobe rules below are chosen so that this chain never stalls, even when the second device fills and later drains.

Top module: `fallthru_fifo`

## Requirements
- R1: While `arst_n` is low, `in_rdy` is 1 and `out_rdy` is 0, and both take these values without waiting for a clock edge. The first two rising edges after `arst_n` rises still hold the block in reset. A strobe held asserted through reset does not count as a new pulse.
- R2: A word is captured at a rising edge when four conditions hold: `shift_in` is 1, `in_rdy` is 1, `shift_in` was sampled 0 at some edge since the previous capture, and the block is out of reset. The captured word is `din`, and `in_rdy` is 0 after that edge.
- R3: Holding `shift_in` high captures one word only. A `shift_in` pulse that both begins and ends while `in_rdy` is 0 captures nothing.
- R4: While `shift_in` stays high after a capture, `in_rdy` stays 0. At the first edge that samples `shift_in` low, the word moves into the interior if the interior has room, and `in_rdy` is 1 after that edge. Once `shift_in` has been sampled low, the word moves at the first edge with room, whatever level `shift_in` has by then.
- R5: In an empty FIFO, a word leaves the input stage at edge E and appears on `dout` with `out_rdy` at 1 after edge E+1.
- R6: A word is consumed at an edge where `shift_out_n` is 0, `shift_out_n` was 1 at the previous edge, and `out_rdy` is 1. `out_rdy` is 0 after that edge. If more words are stored, the next word is shown with `out_rdy` at 1 after the following edge.
- R7: Holding `shift_out_n` low consumes one word only. A falling `shift_out_n` while `out_rdy` is 0 is ignored, and the word that arrives later stays on the outputs until the next valid strobe.
- R8: Words leave in the order they were captured, with none lost and none repeated. The shown word does not change while `out_rdy` is 1 and no consume occurs.
- R9: The FIFO holds 64 words in total: one in the input stage, 62 in the interior and one in the output stage. With 64 words stored, `in_rdy` stays 0, and a further `shift_in` pulse is discarded.
- R10: With `oe_n` high, every bit of `dout` is released to high impedance, so a weak pull on the net sets the level. With `oe_n` low, `dout` drives the output-stage word.
- R11: When two instances are chained as described above, every word written into the first comes out of the second in order. This holds across fill and drain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| arst_n | input | 1 | Master reset, active low, asserts asynchronously |
| din | input | WIDTH | Word to be written |
| shift_in | input | 1 | Write strobe, active high |
| in_rdy | output | 1 | Input stage free to accept a word |
| shift_out_n | input | 1 | Read strobe, active low |
| out_rdy | output | 1 | Valid word present on `dout` |
| oe_n | input | 1 | Output enable, active low; high releases `dout` |
| dout | output | WIDTH | Three-state word output |

## Verification
The main instance is built with WIDTH 4 and DEPTH 64. This makes the full 64-word condition reachable, along with the pointer wrap of the 62-entry interior, which is not a power of two. It also covers the discard of a write beyond capacity. A second, chained pair is built with DEPTH 4, so the downstream device fills within a few words. That puts within reach the case where the upstream word waits with its flag high while the downstream input stage stays busy, and then drains once reading starts. Every clock, a queue-based reference model checks the flags and the shown word of the main instance.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

  // Polarity of a strobe pin: which level means "asserted".
  typedef enum logic {
    STROBE_ACT_HIGH = 1'b0,
    STROBE_ACT_LOW  = 1'b1
  } strobe_pol_e;

endpackage

// File: rtl/ftf_rst_sync.sv
module ftf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift ones in after release; clear at once on assertion.
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ftf_strobe.sv
module ftf_strobe
  import ftf_pkg::*;
#(
  parameter strobe_pol_e POL = STROBE_ACT_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic take,
  output logic asserted,
  output logic armed
);

  logic armed_q;
  logic armed_d;

  if (POL == STROBE_ACT_LOW) begin : g_low
    assign asserted = ~pin;
  end else begin : g_high
    assign asserted = pin;
  end

  // Armed once the strobe is seen idle; disarmed when its pulse is used.
  always_comb begin
    armed_d = armed_q;
    if (!asserted) begin
      armed_d = 1'b1;
    end else if (take) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

endmodule

// File: rtl/ftf_mid_buf.sv
module ftf_mid_buf #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 62
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push ? ptr_next(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? ptr_next(rd_ptr_q) : rd_ptr_q;
    unique case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= wdata;
    end
  end

  assign rdata = mem[rd_ptr_q];
  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8

endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo
  import ftf_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             shift_in,
  output logic             in_rdy,
  input  logic             shift_out_n,
  output logic             out_rdy,
  input  logic             oe_n,
  output wire  [WIDTH-1:0] dout
);

  localparam int MID_DEPTH = DEPTH - 2;

  logic             rst_n_sync;
  logic             si_asrt, si_armed;
  logic             so_asrt, so_armed;
  logic             capture, push, pop, consume;
  logic             mid_full, mid_empty;
  logic [WIDTH-1:0] mid_rdata;

  logic             in_full_q, in_full_d, in_word_en;
  logic [WIDTH-1:0] in_word_q;
  logic             out_full_q, out_full_d, out_word_en;
  logic [WIDTH-1:0] out_word_q;

  ftf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_sync)
  );

  ftf_strobe #(.POL(STROBE_ACT_HIGH)) u_si (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .pin      (shift_in),
    .take     (capture),
    .asserted (si_asrt),
    .armed    (si_armed)
  );

  // Read strobe is a strict edge: re-armed only by an idle sample.
  ftf_strobe #(.POL(STROBE_ACT_LOW)) u_so (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .pin      (shift_out_n),
    .take     (1'b1),
    .asserted (so_asrt),
    .armed    (so_armed)
  );

  ftf_mid_buf #(.WIDTH(WIDTH), .DEPTH(MID_DEPTH)) u_mid (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .push  (push),
    .wdata (in_word_q),
    .pop   (pop),
    .rdata (mid_rdata),
    .full  (mid_full),
    .empty (mid_empty)
  );

  always_comb begin
    capture     = si_asrt & si_armed & ~in_full_q;
    push        = in_full_q & (si_armed | ~si_asrt) & ~mid_full;
    pop         = ~out_full_q & ~mid_empty;
    consume     = so_asrt & so_armed & out_full_q;
    in_word_en  = capture;
    out_word_en = pop;

    in_full_d = in_full_q;
    if (capture) begin
      in_full_d = 1'b1;
    end else if (push) begin
      in_full_d = 1'b0;
    end

    out_full_d = out_full_q;
    if (pop) begin
      out_full_d = 1'b1;
    end else if (consume) begin
      out_full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      in_full_q  <= 1'b0;
      out_full_q <= 1'b0;
    end else begin
      in_full_q  <= in_full_d;
      out_full_q <= out_full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_word_en) begin
      in_word_q <= din;
    end
    if (out_word_en) begin
      out_word_q <= mid_rdata;
    end
  end

  assign in_rdy  = ~in_full_q;
  assign out_rdy = out_full_q;
  assign dout    = oe_n ? {WIDTH{1'bz}} : out_word_q;

  AST_CAPTURE_CLOSES_INPUT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (si_asrt && si_armed && in_rdy) |=> !in_rdy); // R2
  AST_HELD_STROBE_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!in_rdy && si_asrt && !si_armed) |=> !in_rdy); // R4
  AST_CONSUME_CLOSES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (so_asrt && so_armed && out_rdy) |=> !out_rdy); // R6
  AST_SHOWN_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (out_rdy && !(so_asrt && so_armed)) |=> (out_rdy && $stable(out_word_q))); // R8

endmodule

// File: tb/fallthru_fifo_bench.sv
`timescale 1ns/1ps
module fallthru_fifo_bench;

  localparam int W   = 4;
  localparam int D   = 64;
  localparam int MID = D - 2;

  logic         clk = 1'b0;
  logic         arst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic         shift_in = 1'b0;
  logic         shift_out_n = 1'b1;
  logic         oe_n = 1'b0;
  logic         in_rdy, out_rdy;
  wire  [W-1:0] dout_w;

  logic [W-1:0] cdin = '0;
  logic         c_si = 1'b0;
  logic         c_so_n = 1'b1;
  logic         a_in_rdy, a_out_rdy, b_in_rdy, b_out_rdy;
  wire  [W-1:0] a_dout, b_dout;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  for (genvar b = 0; b < W; b++) begin : g_pu
    pullup (dout_w[b]);
  end

  fallthru_fifo u_fallthru_fifo (
    .clk(clk), .arst_n(arst_n), .din(din), .shift_in(shift_in), .in_rdy(in_rdy),
    .shift_out_n(shift_out_n), .out_rdy(out_rdy), .oe_n(oe_n), .dout(dout_w)
  );

  fallthru_fifo #(.DEPTH(4)) u_casc_a (
    .clk(clk), .arst_n(arst_n), .din(cdin), .shift_in(c_si), .in_rdy(a_in_rdy),
    .shift_out_n(b_in_rdy), .out_rdy(a_out_rdy), .oe_n(1'b0), .dout(a_dout)
  );

  fallthru_fifo #(.DEPTH(4)) u_casc_b (
    .clk(clk), .arst_n(arst_n), .din(a_dout), .shift_in(a_out_rdy), .in_rdy(b_in_rdy),
    .shift_out_n(c_so_n), .out_rdy(b_out_rdy), .oe_n(1'b0), .dout(b_dout)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // ---------------- reference model ----------------
  int       sc = 0;
  bit       m_in_full, m_out_full, m_si_arm, m_so_arm;
  logic [W-1:0] m_in_word, m_out_word;
  logic [W-1:0] mq[$];

  task automatic m_clear();
    m_in_full = 0; m_out_full = 0; m_si_arm = 0; m_so_arm = 0;
    mq.delete();
  endtask

  always @(posedge clk) begin
    if (!arst_n) begin
      sc = 0;
      m_clear();
    end else if (sc < 2) begin
      sc++;
      m_clear();
    end else begin
      bit si, so, cap, psh, pp, con;
      si  = shift_in;
      so  = !shift_out_n;
      cap = si && m_si_arm && !m_in_full;
      psh = m_in_full && (m_si_arm || !si) && (mq.size() < MID);
      pp  = !m_out_full && (mq.size() > 0);
      con = so && m_so_arm && m_out_full;
      if (pp) begin
        m_out_word = mq.pop_front();
        m_out_full = 1;
      end else if (con) begin
        m_out_full = 0;
      end
      if (psh) begin
        mq.push_back(m_in_word);
        m_in_full = 0;
      end else if (cap) begin
        m_in_full = 1;
        m_in_word = din;
      end
      m_si_arm = !si ? 1'b1 : (cap ? 1'b0 : m_si_arm);
      m_so_arm = !so;
    end
    #2;
    check("R8 model in_rdy", int'(in_rdy), int'(!m_in_full));
    check("R8 model out_rdy", int'(out_rdy), int'(m_out_full));
    if (m_out_full && !oe_n) check("R8 model dout", int'(dout_w), int'(m_out_word));
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // ---------------- helpers ----------------
  logic [W-1:0] exp_q[$];
  logic [W-1:0] cexp[$];

  task automatic wait_cond(ref logic sig, input string tag);
    int g = 0;
    while (!sig && g < 1000) begin
      @(negedge clk);
      g++;
    end
    if (!sig) check(tag, 0, 1);
  endtask

  task automatic push_word(input logic [W-1:0] w);
    wait_cond(in_rdy, "R2 wait in_rdy");
    exp_q.push_back(w);
    din = w;
    shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_word();
    wait_cond(out_rdy, "R8 wait out_rdy");
    if (exp_q.size() > 0) check("R8 order", int'(dout_w), int'(exp_q.pop_front()));
    else check("R8 unexpected word", 1, 0);
    shift_out_n = 1'b0;
    @(negedge clk);
    shift_out_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0;
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    exp_q.delete();
    repeat (4) @(negedge clk);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset in_rdy", int'(in_rdy), 1);
    check("R1 reset out_rdy", int'(out_rdy), 0);

    // R2/R3/R4/R5: one long pulse
    din = 4'd5; shift_in = 1'b1;
    @(negedge clk);
    check("R2 in_rdy after capture", int'(in_rdy), 0);
    din = 4'd9;
    repeat (2) @(negedge clk);
    check("R4 held strobe keeps word", int'(in_rdy), 0);
    shift_in = 1'b0;
    @(negedge clk);
    check("R4 in_rdy after release", int'(in_rdy), 1);
    check("R5 out_rdy not yet", int'(out_rdy), 0);
    @(negedge clk);
    check("R5 out_rdy latency", int'(out_rdy), 1);
    check("R5 dout word", int'(dout_w), 5);
    repeat (3) @(negedge clk);
    check("R3 single word shown", int'(dout_w), 5);
    shift_out_n = 1'b0;
    @(negedge clk);
    check("R6 out_rdy after consume", int'(out_rdy), 0);
    shift_out_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 only one word captured", int'(out_rdy), 0);

    // R6/R7: held shift_out_n
    push_word(4'd7);
    push_word(4'd8);
    wait_cond(out_rdy, "R6 wait");
    repeat (3) @(negedge clk);
    shift_out_n = 1'b0;
    @(negedge clk);
    check("R6 out_rdy low", int'(out_rdy), 0);
    void'(exp_q.pop_front());
    @(negedge clk);
    check("R6 next word ready", int'(out_rdy), 1);
    check("R6 next word value", int'(dout_w), 8);
    repeat (2) @(negedge clk);
    check("R7 held low consumes one", int'(out_rdy), 1);
    check("R7 held low word", int'(dout_w), 8);
    shift_out_n = 1'b1;
    @(negedge clk);
    pop_word();
    check("R7 empty after", int'(out_rdy), 0);
    shift_out_n = 1'b0;
    @(negedge clk);
    shift_out_n = 1'b1;
    @(negedge clk);
    push_word(4'd3);
    wait_cond(out_rdy, "R7 wait");
    repeat (2) @(negedge clk);
    check("R7 ignored strobe kept word", int'(out_rdy), 1);
    check("R7 ignored strobe word", int'(dout_w), 3);
    pop_word();

    // R10: output enable
    push_word(4'd0);
    wait_cond(out_rdy, "R10 wait");
    oe_n = 1'b1;
    #1;
    check("R10 released dout", int'(dout_w), 15);
    oe_n = 1'b0;
    #1;
    check("R10 driven dout", int'(dout_w), 0);
    @(negedge clk);
    pop_word();

    // R1: asynchronous clear mid-run
    push_word(4'd1);
    push_word(4'd2);
    repeat (3) @(negedge clk);
    #3 arst_n = 1'b0;
    #1;
    check("R1 async in_rdy", int'(in_rdy), 1);
    check("R1 async out_rdy", int'(out_rdy), 0);
    @(negedge clk);
    arst_n = 1'b1;
    exp_q.delete();
    repeat (4) @(negedge clk);
    check("R1 stays empty", int'(out_rdy), 0);

    // R9: capacity
    for (int i = 0; i < D; i++) push_word(W'((i * 5 + 3) % 16));
    repeat (5) @(negedge clk);
    check("R9 full in_rdy", int'(in_rdy), 0);
    din = 4'd15; shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 extra write refused", int'(in_rdy), 0);
    for (int i = 0; i < D; i++) pop_word();
    repeat (5) @(negedge clk);
    check("R9 extra word discarded", int'(out_rdy), 0);
    check("R9 input free again", int'(in_rdy), 1);

    // R11: cascade
    do_reset();
    fork
      begin
        for (int i = 0; i < 12; i++) begin
          wait_cond(a_in_rdy, "R11 wait a_in_rdy");
          cexp.push_back(W'((i * 3 + 2) % 16));
          cdin = W'((i * 3 + 2) % 16);
          c_si = 1'b1;
          @(negedge clk);
          c_si = 1'b0;
          @(negedge clk);
        end
      end
      begin
        repeat (60) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
          wait_cond(b_out_rdy, "R11 wait b_out_rdy");
          if (cexp.size() > 0) check("R11 chain order", int'(b_dout), int'(cexp.pop_front()));
          else check("R11 unexpected word", 1, 0);
          c_so_n = 1'b0;
          @(negedge clk);
          c_so_n = 1'b1;
          @(negedge clk);
        end
      end
    join
    repeat (10) @(negedge clk);
    check("R11 chain drained", int'(b_out_rdy), 0);

    done = 1'b1;
    finish_run();
  end

endmodule